// File: doc/BRIEF.md
# Divide-by-Three Clock Generator with Half-Cycle Balanced Duty

This block takes a source clock and produces a clock at one third of its frequency whose high and low times are equal. A single counter on one edge can only divide by three with a one-third / two-thirds duty. To get a balanced duty, the block runs two identical modulo counters: one on the rising edge of the source clock and one on the falling edge. Each counter drives a registered phase flag that is high for one count out of three. The two flags are offset by half a source period, and the output is their OR. That OR is high for three source half-periods and low for three.

The ratio is a parameter, and any odd value of three or more works. The default, and the case that is verified, is three. An asynchronous active-low reset clears both counters and both phase flags, which holds the output low. After release, each counter starts from zero on the first edge of its own polarity.

Top module: `halfcycle_odd_div`

## Requirements
- R1: The rising-edge counter steps 0, 1, 2 on successive rising source edges and wraps from 2 back to 0. In general it counts 0 to RATIO-1 and wraps. As a result, the output repeats every RATIO source periods (6 half-periods for the default ratio).
- R2: The falling-edge counter runs the same sequence on falling source edges. At any time it is equal to the rising-edge counter or one step away from it.
- R3: Each phase flag is registered and is high exactly while its counter is below (RATIO-1)/2. For the default ratio that means count 0; the flag is low at counts 1 and 2.
- R4: The output is the OR of the two phase flags. Within one output period, sampled once per source half-period starting just after an output rise, the pattern is 1,1,1,0,0,0.
- R5: While rst_n is low, clk_div is low. Asserting rst_n drives clk_div low at once, without any source clock edge.
- R6: After the first output rise, every high pulse and every low pulse of clk_div lasts exactly RATIO source half-periods (3 for the default ratio).
- R7: After reset is released, the first rise of clk_div comes exactly 2*(RATIO-1) source half-periods (4 for the default ratio) after the first source clock edge. This holds whether reset is released while the source clock is high or while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous active-low reset for both counters and both phase flags |
| clk_div | output | 1 | Divided clock, frequency clk_src/RATIO, 50% duty |

## Verification
On every edge of its own polarity, each lane's assertions check the counter range, the wrap from the last count to zero, the single-step advance, and the relation between a phase flag and its count. At the top level, assertions check that the two lanes never drift more than one step apart and that the output stays low during reset. The following can only be shown by the bench's timed scenarios:
- the exact pulse widths in half-periods;
- the latency of the first rise for each reset-release phase;
- the immediate drop of the output on an asynchronous reset.

// File: rtl/oddiv_pkg.sv
package oddiv_pkg;

  // Next value of a modulo-n counter.
  function automatic int unsigned step_count(input int unsigned cur, input int unsigned n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction

  // Number of counts per cycle during which a lane's phase flag is high.
  function automatic int unsigned high_counts(input int unsigned n);
    return (n - 1) / 2;
  endfunction

  // Phase flag decode for a given count.
  function automatic logic phase_on(input int unsigned cur, input int unsigned n);
    return cur < high_counts(n);
  endfunction

endpackage

// File: rtl/oddiv_lane.sv
module oddiv_lane
  import oddiv_pkg::*;
#(
  parameter int unsigned RATIO = 3,
  parameter int unsigned CW    = $clog2(RATIO)
) (
  input  logic          lane_clk,
  input  logic          rst_n,
  output logic [CW-1:0] count,
  output logic          phase
);

  localparam int unsigned HALF = high_counts(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] count_nxt;
  logic          wrap_evt;

  assign wrap_evt  = (count == LAST);
  assign count_nxt = CW'(step_count(int'(count), RATIO));

  always_ff @(posedge lane_clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      phase <= 1'b0;
    end else begin
      count <= count_nxt;
      phase <= phase_on(int'(count_nxt), RATIO);
    end
  end

  // R1 R2
  cnt_range_chk: assert property (@(posedge lane_clk) disable iff (!rst_n)
    count <= LAST);

  // R1 R2
  cnt_wrap_chk: assert property (@(posedge lane_clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0));

  // R1 R2
  cnt_step_chk: assert property (@(posedge lane_clk) disable iff (!rst_n)
    !wrap_evt |=> (count == CW'($past(count) + 1'b1)));

  // R3
  phase_window_chk: assert property (@(posedge lane_clk) disable iff (!rst_n)
    phase |-> (count < CW'(HALF)));

  // R3
  phase_rise_chk: assert property (@(posedge lane_clk) disable iff (!rst_n)
    $rose(phase) |-> (count == '0));

  // R3
  phase_fall_chk: assert property (@(posedge lane_clk) disable iff (!rst_n)
    $fell(phase) |-> (count == CW'(HALF)));

endmodule

// File: rtl/oddiv_merge.sv
module oddiv_merge #(
  parameter int unsigned LANES = 2
) (
  input  logic [LANES-1:0] lane_phase,
  output logic             merged
);

  assign merged = |lane_phase;

endmodule

// File: rtl/halfcycle_odd_div.sv
module halfcycle_odd_div
  import oddiv_pkg::*;
#(
  parameter int unsigned RATIO = 3
) (
  input  logic clk_src,
  input  logic rst_n,
  output logic clk_div
);

  localparam int unsigned CW    = $clog2(RATIO);
  localparam int unsigned LANES = 2;

  wire  [LANES-1:0] lane_clk;
  logic [LANES-1:0] lane_phase;
  logic [CW-1:0]    lane_cnt [LANES];

  // Lane 0 runs on rising source edges, lane 1 on falling ones.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_rise
      assign lane_clk[g] = clk_src;
    end else begin : g_fall
      assign lane_clk[g] = ~clk_src;
    end

    oddiv_lane #(
      .RATIO (RATIO),
      .CW    (CW)
    ) i_lane (
      .lane_clk (lane_clk[g]),
      .rst_n    (rst_n),
      .count    (lane_cnt[g]),
      .phase    (lane_phase[g])
    );
  end

  oddiv_merge #(
    .LANES (LANES)
  ) i_merge (
    .lane_phase (lane_phase),
    .merged     (clk_div)
  );

  // R2
  lanes_close_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (lane_cnt[0] == lane_cnt[1]) ||
    (lane_cnt[0] == CW'(step_count(int'(lane_cnt[1]), RATIO))) ||
    (lane_cnt[1] == CW'(step_count(int'(lane_cnt[0]), RATIO))));

  // R5
  reset_low_chk: assert property (@(posedge clk_src)
    !rst_n |-> !clk_div);

endmodule

// File: tb/test_halfcycle_odd_div.sv
`timescale 1ns/1ps
module test_halfcycle_odd_div;

  localparam int  RATIO = 3;
  localparam real HALF  = 2.5;

  logic clk_src = 1'b0;
  logic rst_n   = 1'b1;
  logic clk_div;

  int total = 0;
  int bad   = 0;

  halfcycle_odd_div #(.RATIO(RATIO)) i_halfcycle_odd_div (
    .clk_src (clk_src),
    .rst_n   (rst_n),
    .clk_div (clk_div)
  );

  always #(HALF) clk_src = ~clk_src;

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int halves(input realtime dt);
    return $rtoi(dt / HALF + 0.5);
  endfunction

  // R5: output low while reset is held
  task automatic t_reset_state();
    #1 rst_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      #(HALF);
      check_eq("R5 low in reset", int'(clk_div), 0);
    end
  endtask

  // R7, R2: first rise latency for a given release phase
  task automatic t_release(input bit during_high);
    realtime t_rel, t_rise;
    rst_n = 1'b0;
    if (during_high) @(posedge clk_src); else @(negedge clk_src);
    #(HALF / 2);
    rst_n = 1'b1;
    t_rel = $realtime;
    @(posedge clk_div);
    t_rise = $realtime;
    check_eq(during_high ? "R7 R2 first rise, release high" : "R7 R1 first rise, release low",
             halves(t_rise - (t_rel + HALF / 2)), 2 * (RATIO - 1));
  endtask

  // R6, R1: high/low widths and period over several pulses
  task automatic t_pulses(input int n);
    realtime t0, t1, t2;
    @(posedge clk_div);
    t0 = $realtime;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_div);
      t1 = $realtime;
      @(posedge clk_div);
      t2 = $realtime;
      check_eq("R6 high width", halves(t1 - t0), RATIO);
      check_eq("R6 low width", halves(t2 - t1), RATIO);
      check_eq("R1 period", halves(t2 - t0), 2 * RATIO);
      t0 = t2;
    end
  endtask

  // R4, R3: sampled shape over one output period
  task automatic t_shape();
    @(posedge clk_div);
    #(HALF / 2);
    for (int k = 0; k < 2 * RATIO; k++) begin
      check_eq("R4 R3 half-period sample", int'(clk_div), (k < RATIO) ? 1 : 0);
      #(HALF);
    end
  endtask

  // R5: asynchronous clear while output is high
  task automatic t_async_reset();
    @(posedge clk_div);
    #0.5 rst_n = 1'b0;
    #0.3;
    check_eq("R5 async clear", int'(clk_div), 0);
    for (int k = 0; k < 6; k++) begin
      #(HALF);
      check_eq("R5 held low", int'(clk_div), 0);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000.0 * 2 * HALF);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_release(1'b0);
    t_pulses(5);
    t_shape();
    t_async_reset();
    t_release(1'b1);
    t_pulses(5);
    t_shape();
    t_async_reset();
    t_release(1'b0);
    t_shape();
    finish_run();
  end

endmodule